// File: doc/BRIEF.md
# Banked Warp Scratchpad

This block is an on-chip scratchpad built from a set of independent single-port banks. It takes one memory request from a whole warp at a time. Each lane of the warp carries an enable bit, a direction bit, a word address and a write value. Consecutive word addresses go to consecutive banks, so lanes that touch different banks are all served in the same cycle.

When two or more active lanes want different words from the same bank, the request is replayed over several passes. In each pass every bank serves one word. That word is the one wanted by the lowest-numbered lane still waiting on that bank, and it goes to every waiting lane that asked for it. A word shared by many lanes therefore costs a single read, whether every lane shares it or only some do.

The block raises `busy` while it works through the passes. It then pulses `done` for one cycle, with all per-lane read data and the number of passes used held stable on the outputs.

Top module: `warp_bank_scratch`

## Requirements
- R1: Word address `a` lives in bank `a mod BANKS` at row `a / BANKS`, taking the low log2(BANKS) address bits as the bank number; with 32 banks, word 32 is the second word of bank 0.
- R2: A request in which no bank is asked for more than one distinct word completes in exactly one pass (for example lane*1, lane*3, lane*129 and lane+71).
- R3: When the worst bank is asked for N distinct words, the request takes exactly N passes (lane*2 gives 2, lane*8 gives 8, lane*128 gives 32).
- R4: When every active lane reads the same word, the request completes in one pass and every lane returns that word.
- R5: Lanes sharing a word inside a bank add no pass: lane/2 completes in one pass. Two shared words in one bank cost exactly two passes.
- R6: A read returns the value most recently written to that word by an earlier request.
- R7: When several lanes of one request write the same word, the value from the highest-numbered writing lane is stored.
- R8: A read and a write to the same word in one request return the value held before the request.
- R9: Inactive lanes take no part in conflict counting and return zero. Write lanes also return zero. A request with no active lane completes with a pass count of 0.
- R10: `busy` rises on the cycle after acceptance and stays high for max(passes,1) cycles. `done` is a one-cycle pulse in the cycle after `busy` falls, and `pass_count` holds the number of passes at that time.
- R11: A request presented while `busy` is high is ignored and leaves the storage unchanged.
- R12: After reset, `busy`, `done` and `pass_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Offer a warp request; accepted when not busy |
| req_active | input | LANES | Per-lane enable |
| req_write | input | LANES | Per-lane direction, 1 = write |
| req_addr | input | LANES*ADDR_W | Per-lane word address, lane l at bits [l*ADDR_W +: ADDR_W] |
| req_wdata | input | LANES*DATA_W | Per-lane write value |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | LANES*DATA_W | Per-lane read result, valid with done |
| pass_count | output | clog2(LANES+1) | Passes used by the last request |

## Verification
The assertions rely on the request fields being stable only at the accepting edge. They also rely on `req_valid` being free to stay high during a busy period, which the design must then ignore. The stimulus raises `req_valid` only when the block is idle, except in one deliberate sequence. That sequence holds a conflicting write high during a long replay to exercise the refusal. Every address stays inside the configured address width, so the model's view of bank and row matches the hardware's.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
   typedef enum logic {
      WBS_IDLE = 1'b0,
      WBS_RUN  = 1'b1
   } wbs_state_e;
endpackage

// File: rtl/wbs_bank.sv
module wbs_bank #(
   parameter int LANES   = 32,
   parameter int BANKS   = 32,
   parameter int ADDR_W  = 10,
   parameter int DATA_W  = 32,
   parameter int BANK_ID = 0
) (
   input  logic                      clk,
   input  logic [LANES-1:0]          pend,
   input  logic [LANES-1:0]          wr,
   input  logic [LANES*ADDR_W-1:0]   addr,
   input  logic [LANES*DATA_W-1:0]   wdata,
   output logic [LANES-1:0]          served,
   output logic [DATA_W-1:0]         rdata
);
   localparam int BW    = $clog2(BANKS);
   localparam int ROW_W = ADDR_W - BW;
   localparam int ROWS  = 1 << ROW_W;
   localparam logic [BW-1:0] ID_V = BW'(BANK_ID);

   logic [DATA_W-1:0] mem [ROWS];
   logic [ROW_W-1:0]  row_sel;
   logic              found;
   logic              we;
   logic [DATA_W-1:0] wd;

   // lowest pending lane mapped here picks the word served this pass (R1)
   always_comb begin
      found   = 1'b0;
      row_sel = '0;
      for (int l = 0; l < LANES; l++) begin
         if (!found && pend[l] && addr[l*ADDR_W +: BW] == ID_V) begin
            found   = 1'b1;
            row_sel = addr[l*ADDR_W + BW +: ROW_W];
         end
      end
   end

   // every pending lane wanting the chosen word shares this pass (R4, R5)
   always_comb begin
      served = '0;
      for (int l = 0; l < LANES; l++) begin
         served[l] = found && pend[l] &&
                     addr[l*ADDR_W +: BW] == ID_V &&
                     addr[l*ADDR_W + BW +: ROW_W] == row_sel;
      end
   end

   // highest served writer wins (R7)
   always_comb begin
      we = 1'b0;
      wd = '0;
      for (int l = 0; l < LANES; l++) begin
         if (served[l] && wr[l]) begin
            we = 1'b1;
            wd = wdata[l*DATA_W +: DATA_W];
         end
      end
   end

   // old contents seen by readers in the pass that writes (R8)
   assign rdata = mem[row_sel];

   always_ff @(posedge clk) begin
      if (we) mem[row_sel] <= wd;
   end
endmodule

// File: rtl/wbs_lane_collect.sv
module wbs_lane_collect #(
   parameter int BANKS  = 32,
   parameter int DATA_W = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clear,
   input  logic                       take,
   input  logic [$clog2(BANKS)-1:0]   bank_sel,
   input  logic [BANKS*DATA_W-1:0]    rd_bus,
   output logic [DATA_W-1:0]          data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     data <= '0;
      else if (clear) data <= '0;   // R9: unserved lanes read zero
      else if (take)  data <= rd_bus[bank_sel*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/warp_bank_scratch.sv
module warp_bank_scratch #(
   parameter int LANES  = 32,
   parameter int BANKS  = 32,
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic [LANES-1:0]              req_active,
   input  logic [LANES-1:0]              req_write,
   input  logic [LANES*ADDR_W-1:0]       req_addr,
   input  logic [LANES*DATA_W-1:0]       req_wdata,
   output logic                          busy,
   output logic                          done,
   output logic [LANES*DATA_W-1:0]       rd_data,
   output logic [$clog2(LANES+1)-1:0]    pass_count
);
   import wbs_pkg::*;

   localparam int BW   = $clog2(BANKS);
   localparam int PC_W = $clog2(LANES+1);

   initial begin
      AST_BANKS_POW2: assert (BANKS == (1 << BW) && BANKS >= 2)
         else $error("BANKS must be a power of two");            // R1
      AST_ADDR_ROOM: assert (ADDR_W > BW)
         else $error("ADDR_W must exceed bank select width");    // R1
   end

   wbs_state_e              state_q;
   logic [LANES-1:0]        pend_q, wr_q;
   logic [LANES*ADDR_W-1:0] addr_q;
   logic [LANES*DATA_W-1:0] wdata_q;
   logic                    done_q;
   logic [PC_W-1:0]         pass_q;

   logic [LANES-1:0]        served_bk [BANKS];
   logic [BANKS*DATA_W-1:0] rd_bus;
   logic [LANES-1:0]        served_all;
   logic                    run, accept, finish;

   assign run    = (state_q == WBS_RUN);
   assign accept = req_valid && !run;    // R11
   assign finish = run && ((pend_q & ~served_all) == '0);

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      wbs_bank #(
         .LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W),
         .DATA_W(DATA_W), .BANK_ID(b)
      ) bank_i (
         .clk    (clk),
         .pend   (pend_q),
         .wr     (wr_q),
         .addr   (addr_q),
         .wdata  (wdata_q),
         .served (served_bk[b]),
         .rdata  (rd_bus[b*DATA_W +: DATA_W])
      );
   end

   always_comb begin
      served_all = '0;
      for (int b = 0; b < BANKS; b++) served_all |= served_bk[b];
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      wbs_lane_collect #(.BANKS(BANKS), .DATA_W(DATA_W)) col_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .clear    (accept),
         .take     (run && served_all[l] && !wr_q[l]),
         .bank_sel (addr_q[l*ADDR_W +: BW]),
         .rd_bus   (rd_bus),
         .data     (rd_data[l*DATA_W +: DATA_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WBS_IDLE;
         pend_q  <= '0;
         wr_q    <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         done_q  <= 1'b0;
         pass_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            state_q <= WBS_RUN;
            pend_q  <= req_active;          // R9
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            pass_q  <= '0;
         end else if (run) begin
            pend_q <= pend_q & ~served_all;
            if (|served_all) pass_q <= pass_q + PC_W'(1);   // R3
            if (finish) begin
               state_q <= WBS_IDLE;
               done_q  <= 1'b1;             // R10
            end
         end
      end
   end

   assign busy       = run;
   assign done       = done_q;
   assign pass_count = pass_q;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                        // R10
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));                       // R10
   AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (pend_q == '0));                              // R10
   AST_NO_NEW_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> ((pend_q & ~$past(pend_q)) == '0));     // R11
   AST_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && |pend_q) |=> ($countones(pend_q) < $countones($past(pend_q))));  // R3
   AST_PASS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      32'(pass_count) <= LANES);                              // R3
endmodule

// File: tb/warp_bank_scratch_tb_top.sv
module warp_bank_scratch_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int LANES  = 32;
   localparam int BANKS  = 32;
   localparam int AW     = 12;
   localparam int DW     = 32;
   localparam int PC_W   = $clog2(LANES+1);
   localparam int WORDS  = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [LANES-1:0]    req_active = '0, req_write = '0;
   logic [LANES*AW-1:0] req_addr = '0;
   logic [LANES*DW-1:0] req_wdata = '0;
   logic busy, done;
   logic [LANES*DW-1:0] rd_data;
   logic [PC_W-1:0]     pass_count;

   always #(CLK_PERIOD/2) clk = ~clk;

   warp_bank_scratch #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_active(req_active),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rd_data(rd_data), .pass_count(pass_count));

   typedef struct {
      logic [LANES*DW-1:0] rd;
      int                  passes;
      string               tag;
   } exp_t;

   exp_t  sb_q[$];
   int    n_vec = 0, n_bad = 0;
   int    busy_cycles = 0;
   int    cyc = 0;

   logic [DW-1:0]       mdl [WORDS];
   logic [LANES-1:0]    b_act, b_wr;
   logic [AW-1:0]       b_addr [LANES];
   logic [DW-1:0]       b_wd   [LANES];

   function automatic logic [DW-1:0] fill_val(input int a);
      return (32'(a) * 32'h01000193) ^ 32'hC3A5_0F1E;
   endfunction

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   // watchdog: counts as a failed check
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cyc);
         finish_run();
      end
   end

   // monitor: measure busy length and score each completion
   always @(negedge clk) begin
      if (rst_n && busy) busy_cycles++;
      if (rst_n && done) begin
         if (sb_q.size() == 0) begin
            n_vec++; n_bad++;
            $display("FAIL R10: actual done with no request pending, expected none");
         end else begin
            exp_t e;
            int   bad, exp_busy;
            e = sb_q.pop_front();
            n_vec++;
            bad = 0;
            for (int l = 0; l < LANES; l++) begin
               if (rd_data[l*DW +: DW] !== e.rd[l*DW +: DW]) begin
                  if (bad == 0)
                     $display("FAIL %s lane %0d data: actual %h expected %h",
                              e.tag, l, rd_data[l*DW +: DW], e.rd[l*DW +: DW]);
                  bad++;
               end
            end
            if (32'(pass_count) != e.passes) begin
               $display("FAIL %s passes: actual %0d expected %0d", e.tag, pass_count, e.passes);
               bad++;
            end
            exp_busy = (e.passes > 1) ? e.passes : 1;
            if (busy_cycles != exp_busy) begin
               $display("FAIL R10 (%s) busy cycles: actual %0d expected %0d",
                        e.tag, busy_cycles, exp_busy);
               bad++;
            end
            if (bad != 0) n_bad++;
         end
         busy_cycles = 0;
      end
   end

   // driver: compute expectation, push to scoreboard, drive, wait for drain
   task automatic issue(input string tag, input bit poke = 1'b0);
      exp_t e;
      int   worst;
      e.tag = tag;
      e.rd  = '0;
      for (int l = 0; l < LANES; l++)
         if (b_act[l] && !b_wr[l]) e.rd[l*DW +: DW] = mdl[b_addr[l]];
      worst = 0;
      for (int b = 0; b < BANKS; b++) begin
         int cnt = 0;
         for (int l = 0; l < LANES; l++) begin
            bit seen = 1'b0;
            if (!b_act[l] || 32'(b_addr[l]) % BANKS != b) continue;
            for (int j = 0; j < l; j++)
               if (b_act[j] && b_addr[j] == b_addr[l]) seen = 1'b1;
            if (!seen) cnt++;
         end
         if (cnt > worst) worst = cnt;
      end
      e.passes = worst;
      for (int l = 0; l < LANES; l++)
         if (b_act[l] && b_wr[l]) mdl[b_addr[l]] = b_wd[l];
      sb_q.push_back(e);

      @(negedge clk);
      req_active = b_act;
      req_write  = b_wr;
      for (int l = 0; l < LANES; l++) begin
         req_addr[l*AW +: AW]  = b_addr[l];
         req_wdata[l*DW +: DW] = b_wd[l];
      end
      req_valid = 1'b1;
      @(negedge clk);
      if (poke) begin
         req_active = '1;
         req_write  = '1;
         for (int l = 0; l < LANES; l++) begin
            req_addr[l*AW +: AW]  = AW'(5);
            req_wdata[l*DW +: DW] = 32'hDEAD_0000 + 32'(l);
         end
         repeat (3) @(negedge clk);
      end
      req_valid = 1'b0;
      while (sb_q.size() != 0) @(posedge clk);
   endtask

   task automatic set_pattern(input int mul, input int div, input int add, input bit wr);
      b_act = '1;
      b_wr  = wr ? '1 : '0;
      for (int l = 0; l < LANES; l++) begin
         b_addr[l] = AW'((l * mul) / div + add);
         b_wd[l]   = fill_val(l * mul / div + add);
      end
   endtask

   initial begin
      int seed;
      for (int a = 0; a < WORDS; a++) mdl[a] = 'x;
      repeat (3) @(negedge clk);
      // R12: reset state
      n_vec++;
      if (busy !== 1'b0 || done !== 1'b0 || pass_count !== '0) begin
         n_bad++;
         $display("FAIL R12: actual busy=%b done=%b passes=%0d expected 0 0 0",
                  busy, done, pass_count);
      end
      rst_n = 1'b1;

      // R6 / R2: fill the whole store with stride-1 writes
      for (int k = 0; k < WORDS / LANES; k++) begin
         set_pattern(1, 1, k * LANES, 1'b1);
         issue("R6 fill");
      end

      set_pattern(1, 1, 0, 1'b0);    issue("R2 stride1");
      set_pattern(3, 1, 0, 1'b0);    issue("R2 stride3");
      set_pattern(129, 1, 0, 1'b0);  issue("R2 stride129");
      set_pattern(1, 1, 71, 1'b0);   issue("R1 offset71");
      set_pattern(2, 1, 0, 1'b0);    issue("R3 stride2");
      set_pattern(8, 1, 0, 1'b0);    issue("R3 stride8");
      set_pattern(128, 1, 0, 1'b0);  issue("R3 stride128");
      set_pattern(32, 1, 1, 1'b0);   issue("R1 bank-wrap stride32");
      set_pattern(0, 1, 7, 1'b0);    issue("R4 broadcast");
      set_pattern(1, 2, 0, 1'b0);    issue("R5 multicast");

      // R5: two shared words in bank 0 -> two passes
      set_pattern(1, 1, 0, 1'b0);
      for (int l = 0; l < LANES; l++) b_addr[l] = (l < 16) ? AW'(0) : AW'(32);
      issue("R5 two shared words");

      // R7: all lanes write word 40, highest lane wins; then read back
      set_pattern(0, 1, 40, 1'b1);
      for (int l = 0; l < LANES; l++) b_wd[l] = 32'hA000_0000 + 32'(l);
      issue("R7 write collide");
      set_pattern(0, 1, 40, 1'b0);   issue("R7 readback");

      // R8: lane 0 reads word 50 while lane 1 writes it
      set_pattern(1, 1, 0, 1'b0);
      b_act = 32'h3;
      b_addr[0] = AW'(50); b_addr[1] = AW'(50);
      b_wr = 32'h2; b_wd[1] = 32'h5555_AAAA;
      issue("R8 read-old");
      set_pattern(0, 1, 50, 1'b0);   issue("R8 readback");

      // R9: only even lanes active, all in bank 0; odd lanes would add conflicts
      set_pattern(32, 1, 0, 1'b0);
      b_act = 32'h5555_5555;
      issue("R9 inactive lanes");
      b_act = '0;                    issue("R9 empty request");

      // R11: write requests held during a long replay are ignored
      set_pattern(8, 1, 0, 1'b0);    issue("R11 busy refusal", 1'b1);
      set_pattern(0, 1, 5, 1'b0);    issue("R11 word 5 untouched");

      // R6: mixed pseudo-random requests
      seed = 32'h1234_5678;
      for (int n = 0; n < 40; n++) begin
         for (int l = 0; l < LANES; l++) begin
            seed = seed * 1103515245 + 12345;
            b_addr[l] = AW'(seed >>> 8);
            b_act[l]  = seed[3] | seed[4];
            b_wr[l]   = seed[5] & seed[6];
            b_wd[l]   = 32'(seed) ^ 32'h0BAD_F00D;
         end
         issue("R6 mixed");
      end

      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule